// File: doc/BRIEF.md
# GCD Unit Self-Test Controller

This block runs a built-in self-test on an external 8-bit greatest-common-divisor unit. A pulse on the start input loads a 16-bit pseudo-random generator from a seed. The block then works through a set number of test vectors. For each vector it takes two operand bytes from the generator and presents them to the unit under test with a one-cycle start strobe. It then waits for the unit's done flag. The unit's answer is compared with a result that the block computes on its own, using a subtractive Euclid engine.

When the run ends, the block raises a done flag together with a pass or a fail verdict, and reports how many vectors it applied. The first failing vector is kept for readout: its operand pair, the expected value and the value the unit returned. A per-vector watchdog catches a unit that never finishes. It marks that vector as failed, and the run then goes on to the next vector.

Top module: `gcdbist_top`

## Requirements
- R1: After reset, testDone, testPass, testFail, wdogTrip and cutStart are 0, and vectorsApplied is 0.
- R2: A one-cycle testStart pulse, while idle or after a run has finished, begins a new run. At that pulse the block samples seed and numVectors and clears the verdict, the count and the capture. A seed of zero is replaced by 16'hACE1.
- R3: The generator is a 16-bit shift register. Each step shifts it left by one bit and loads bit 0 with s[15]^s[13]^s[12]^s[10]. Vector k uses the state after k steps, so vector 0 is the seed itself. cutOpA carries bits 15:8 and cutOpB carries bits 7:0.
- R4: cutStart is a single-cycle pulse. cutOpA and cutOpB are valid in that cycle and stay unchanged until the next vector. cutResult is sampled in the first cycle after the pulse in which cutDone is high.
- R5: The reference engine gives gcd(a,0)=a and gcd(0,b)=b. Otherwise it subtracts the smaller value from the larger, one step per cycle, until the two are equal.
- R6: Every vector's result is compared with the reference. Any mismatch sets testFail, and testFail stays set until the next run starts.
- R7: On the first failing vector of a run, failOpA, failOpB, failExpected and failActual are latched. Later failures in the same run leave them unchanged.
- R8: If cutDone does not come within 64 cycles after cutStart, the vector fails, wdogTrip is set, the captured actual value reads 0, and the run goes on.
- R9: A run applies exactly numVectors vectors, or 256 when numVectors is 0. It keeps going after a failure, and vectorsApplied reports the number of vectors finished.
- R10: At the end of a run, testDone is 1 and testPass equals the inverse of testFail. Both hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| testStart | input | 1 | Start pulse for a self-test run |
| seed | input | 16 | Generator seed, sampled at start |
| numVectors | input | 16 | Vectors to apply, 0 selects 256 |
| cutStart | output | 1 | Start strobe to the unit under test |
| cutOpA | output | 8 | First operand to the unit |
| cutOpB | output | 8 | Second operand to the unit |
| cutDone | input | 1 | Unit reports its result is ready |
| cutResult | input | 8 | Result from the unit |
| testDone | output | 1 | Run finished |
| testPass | output | 1 | Run finished without failure |
| testFail | output | 1 | Sticky failure flag of the current run |
| wdogTrip | output | 1 | Sticky flag: some vector timed out |
| vectorsApplied | output | 16 | Vectors completed in this run |
| failOpA | output | 8 | First operand of the first failing vector |
| failOpB | output | 8 | Second operand of the first failing vector |
| failExpected | output | 8 | Reference result of the first failing vector |
| failActual | output | 8 | Unit result of the first failing vector |

## Verification
A wrong generator state shows up on cutOpA and cutOpB at the very next start strobe, because each strobe can be matched against a bench model of the sequence. A faulty reference engine or comparator shows up as a false testFail, and the capture registers name the offending pair as soon as the run ends. A broken counter or watchdog changes either vectorsApplied or the number of start strobes seen by the bench. It can also leave testDone stuck low, which the bench watchdog catches within a bounded number of cycles.

// File: rtl/gcdbist_pkg.sv
package gcdbist_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_GEN   = 3'd1,
    ST_APPLY = 3'd2,
    ST_WAIT  = 3'd3,
    ST_CHECK = 3'd4,
    ST_DONE  = 3'd5
  } bistState_t;

  typedef struct packed {
    logic clearRun;   // sample seed/count, clear verdict and capture
    logic genStep;    // take operands from generator, advance it
    logic applyStart; // strobe the unit and the reference engine
    logic checkNow;   // compare and count the current vector
  } bistStrobe_t;

endpackage

// File: rtl/gcdbist_lfsr.sv
module gcdbist_lfsr #(
  parameter int          W        = 16,
  parameter logic [15:0] TAP_MASK = 16'hB400,
  parameter logic [15:0] DEF_SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic [W-1:0] seedIn,
  input  logic         step,
  output logic [W-1:0] state
);

  logic [W-1:0] tapBits;
  logic         feedBit;
  logic [W-1:0] seedUse;

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_tap
      assign tapBits[gi] = TAP_MASK[gi] ? state[gi] : 1'b0;
    end
  endgenerate

  assign feedBit = ^tapBits;
  assign seedUse = (seedIn == '0) ? DEF_SEED[W-1:0] : seedIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= DEF_SEED[W-1:0];
    end else if (load) begin
      state <= seedUse;
    end else if (step) begin
      state <= {state[W-2:0], feedBit};
    end
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    state != '0); // R3

endmodule

// File: rtl/gcdbist_refgcd.sv
module gcdbist_refgcd #(
  parameter int OP_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [OP_W-1:0] opA,
  input  logic [OP_W-1:0] opB,
  output logic            busy,
  output logic [OP_W-1:0] result
);

  logic [OP_W-1:0] xReg;
  logic [OP_W-1:0] yReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      xReg   <= '0;
      yReg   <= '0;
      result <= '0;
    end else if (start) begin
      busy <= 1'b1;
      xReg <= opA;
      yReg <= opB;
    end else if (busy) begin
      if (yReg == '0) begin
        result <= xReg;
        busy   <= 1'b0;
      end else if (xReg == '0) begin
        result <= yReg;
        busy   <= 1'b0;
      end else if (xReg == yReg) begin
        result <= xReg;
        busy   <= 1'b0;
      end else if (xReg > yReg) begin
        xReg <= xReg - yReg;
      end else begin
        yReg <= yReg - xReg;
      end
    end
  end

  AST_REF_SHRINK: assert property (@(posedge clk) disable iff (!rstN)
    busy && !start |=> (xReg <= $past(xReg)) && (yReg <= $past(yReg))); // R5

  AST_REF_NONZERO_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) && ($past(xReg) != '0 || $past(yReg) != '0) |-> result != '0); // R5

endmodule

// File: rtl/gcdbist_datapath.sv
module gcdbist_datapath
  import gcdbist_pkg::*;
#(
  parameter int          OP_W        = 8,
  parameter int          LFSR_W      = 16,
  parameter int          CNT_W       = 16,
  parameter int          DEF_VECTORS = 256,
  parameter int          WDOG_LIMIT  = 64,
  parameter logic [15:0] TAP_MASK    = 16'hB400,
  parameter logic [15:0] DEF_SEED    = 16'hACE1
) (
  input  logic              clk,
  input  logic              rstN,
  input  bistStrobe_t       strobe,
  input  logic              inWait,
  input  logic [LFSR_W-1:0] seed,
  input  logic [CNT_W-1:0]  numVectors,
  input  logic              cutDone,
  input  logic [OP_W-1:0]   cutResult,
  output logic [OP_W-1:0]   cutOpA,
  output logic [OP_W-1:0]   cutOpB,
  output logic              waitOver,
  output logic              lastVec,
  output logic              failSticky,
  output logic              wdogSticky,
  output logic [CNT_W-1:0]  vecCount,
  output logic [OP_W-1:0]   failOpA,
  output logic [OP_W-1:0]   failOpB,
  output logic [OP_W-1:0]   failExpected,
  output logic [OP_W-1:0]   failActual
);

  localparam int WD_W = $clog2(WDOG_LIMIT + 1);
  localparam logic [WD_W-1:0] WD_MAX = WD_W'(WDOG_LIMIT);
  localparam logic [CNT_W-1:0] DEF_CNT = CNT_W'(DEF_VECTORS);

  logic [LFSR_W-1:0] lfsrState;
  logic              refBusy;
  logic [OP_W-1:0]   refResult;
  logic              gotCut;
  logic [OP_W-1:0]   cutLatched;
  logic [WD_W-1:0]   wdCount;
  logic              timedOut;
  logic [CNT_W-1:0]  targetCnt;
  logic              mismatch;

  gcdbist_lfsr #(
    .W(LFSR_W), .TAP_MASK(TAP_MASK), .DEF_SEED(DEF_SEED)
  ) lfsr_i (
    .clk(clk), .rstN(rstN), .load(strobe.clearRun), .seedIn(seed),
    .step(strobe.genStep), .state(lfsrState)
  );

  gcdbist_refgcd #(.OP_W(OP_W)) ref_i (
    .clk(clk), .rstN(rstN), .start(strobe.applyStart),
    .opA(cutOpA), .opB(cutOpB), .busy(refBusy), .result(refResult)
  );

  // operand registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cutOpA <= '0;
      cutOpB <= '0;
    end else if (strobe.genStep) begin
      cutOpA <= lfsrState[LFSR_W-1 -: OP_W];
      cutOpB <= lfsrState[OP_W-1:0];
    end
  end

  // response capture and watchdog
  assign timedOut = (wdCount == WD_MAX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gotCut     <= 1'b0;
      cutLatched <= '0;
      wdCount    <= '0;
    end else if (strobe.applyStart) begin
      gotCut     <= 1'b0;
      cutLatched <= '0;
      wdCount    <= '0;
    end else if (inWait && !gotCut && !timedOut) begin
      if (cutDone) begin
        gotCut     <= 1'b1;
        cutLatched <= cutResult;
      end else begin
        wdCount <= wdCount + 1'b1;
      end
    end
  end

  assign waitOver = (gotCut || timedOut) && !refBusy;

  // vector counting
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecCount  <= '0;
      targetCnt <= DEF_CNT;
    end else if (strobe.clearRun) begin
      vecCount  <= '0;
      targetCnt <= (numVectors == '0) ? DEF_CNT : numVectors;
    end else if (strobe.checkNow) begin
      vecCount <= vecCount + 1'b1;
    end
  end

  assign lastVec = (vecCount == targetCnt - 1'b1);

  // comparison and first-failure capture
  assign mismatch = timedOut || (cutLatched != refResult);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearRun) begin
      failSticky   <= 1'b0;
      wdogSticky   <= 1'b0;
      failOpA      <= '0;
      failOpB      <= '0;
      failExpected <= '0;
      failActual   <= '0;
    end else if (strobe.checkNow) begin
      if (timedOut) begin
        wdogSticky <= 1'b1;
      end
      if (mismatch) begin
        failSticky <= 1'b1;
        if (!failSticky) begin
          failOpA      <= cutOpA;
          failOpB      <= cutOpB;
          failExpected <= refResult;
          failActual   <= cutLatched;
        end
      end
    end
  end

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    failSticky && !strobe.clearRun |=> failSticky); // R6

  AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    failSticky && !strobe.clearRun |=> $stable(failOpA) && $stable(failOpB)
      && $stable(failExpected) && $stable(failActual)); // R7

  AST_OPS_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    inWait |-> $stable(cutOpA) && $stable(cutOpB)); // R4

  AST_WDOG_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    wdCount <= WD_MAX); // R8

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    vecCount <= targetCnt); // R9

endmodule

// File: rtl/gcdbist_ctrl.sv
module gcdbist_ctrl
  import gcdbist_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        testStart,
  input  logic        waitOver,
  input  logic        lastVec,
  output bistStrobe_t strobe,
  output logic        inWait,
  output logic        cutStart,
  output logic        testDone
);

  bistState_t state;
  bistState_t nextState;
  logic       canStart;

  assign canStart = (state == ST_IDLE) || (state == ST_DONE);

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (testStart) begin
          strobe.clearRun = 1'b1;
          nextState       = ST_GEN;
        end
      end
      ST_GEN: begin
        strobe.genStep = 1'b1;
        nextState      = ST_APPLY;
      end
      ST_APPLY: begin
        strobe.applyStart = 1'b1;
        nextState         = ST_WAIT;
      end
      ST_WAIT: begin
        if (waitOver) nextState = ST_CHECK;
      end
      ST_CHECK: begin
        strobe.checkNow = 1'b1;
        nextState       = lastVec ? ST_DONE : ST_GEN;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign inWait   = (state == ST_WAIT);
  assign cutStart = (state == ST_APPLY);
  assign testDone = (state == ST_DONE);

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    cutStart |=> !cutStart); // R4

  AST_RUN_BEGINS: assert property (@(posedge clk) disable iff (!rstN)
    canStart && testStart |=> !testDone && !cutStart); // R2

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    testDone && !testStart |=> testDone); // R10

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe)); // R4

endmodule

// File: rtl/gcdbist_top.sv
module gcdbist_top
  import gcdbist_pkg::*;
#(
  parameter int          OP_W        = 8,
  parameter int          LFSR_W      = 16,
  parameter int          CNT_W       = 16,
  parameter int          DEF_VECTORS = 256,
  parameter int          WDOG_LIMIT  = 64,
  parameter logic [15:0] TAP_MASK    = 16'hB400,
  parameter logic [15:0] DEF_SEED    = 16'hACE1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              testStart,
  input  logic [LFSR_W-1:0] seed,
  input  logic [CNT_W-1:0]  numVectors,
  output logic              cutStart,
  output logic [OP_W-1:0]   cutOpA,
  output logic [OP_W-1:0]   cutOpB,
  input  logic              cutDone,
  input  logic [OP_W-1:0]   cutResult,
  output logic              testDone,
  output logic              testPass,
  output logic              testFail,
  output logic              wdogTrip,
  output logic [CNT_W-1:0]  vectorsApplied,
  output logic [OP_W-1:0]   failOpA,
  output logic [OP_W-1:0]   failOpB,
  output logic [OP_W-1:0]   failExpected,
  output logic [OP_W-1:0]   failActual
);

  bistStrobe_t strobe;
  logic        inWait;
  logic        waitOver;
  logic        lastVec;

  gcdbist_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .testStart(testStart), .waitOver(waitOver),
    .lastVec(lastVec), .strobe(strobe), .inWait(inWait),
    .cutStart(cutStart), .testDone(testDone)
  );

  gcdbist_datapath #(
    .OP_W(OP_W), .LFSR_W(LFSR_W), .CNT_W(CNT_W), .DEF_VECTORS(DEF_VECTORS),
    .WDOG_LIMIT(WDOG_LIMIT), .TAP_MASK(TAP_MASK), .DEF_SEED(DEF_SEED)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inWait(inWait), .seed(seed),
    .numVectors(numVectors), .cutDone(cutDone), .cutResult(cutResult),
    .cutOpA(cutOpA), .cutOpB(cutOpB), .waitOver(waitOver), .lastVec(lastVec),
    .failSticky(testFail), .wdogSticky(wdogTrip), .vecCount(vectorsApplied),
    .failOpA(failOpA), .failOpB(failOpB), .failExpected(failExpected),
    .failActual(failActual)
  );

  assign testPass = testDone && !testFail;

  AST_PASS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(testPass && testFail)); // R10

endmodule

// File: tb/gcdbist_top_tb_top.sv
module gcdbist_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        testStart;
  logic [15:0] seed;
  logic [15:0] numVectors;
  logic        cutStart;
  logic [7:0]  cutOpA, cutOpB;
  logic        cutDone;
  logic [7:0]  cutResult;
  logic        testDone, testPass, testFail, wdogTrip;
  logic [15:0] vectorsApplied;
  logic [7:0]  failOpA, failOpB, failExpected, failActual;

  int checks = 0;
  int errors = 0;

  // unit-under-test model controls
  int   startCnt;
  int   opErrs;
  logic [15:0] expState;
  int   badIdx1, badIdx2, hangIdx;
  logic       mdlBusy;
  int         mdlLat;
  int         mdlIdx;
  logic [7:0] mdlA, mdlB;

  always #4 clk = ~clk; // 125 MHz

  gcdbist_top dut_i (
    .clk(clk), .rstN(rstN), .testStart(testStart), .seed(seed),
    .numVectors(numVectors), .cutStart(cutStart), .cutOpA(cutOpA),
    .cutOpB(cutOpB), .cutDone(cutDone), .cutResult(cutResult),
    .testDone(testDone), .testPass(testPass), .testFail(testFail),
    .wdogTrip(wdogTrip), .vectorsApplied(vectorsApplied), .failOpA(failOpA),
    .failOpB(failOpB), .failExpected(failExpected), .failActual(failActual)
  );

  function automatic logic [15:0] stepLfsr(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [15:0] nthState(input logic [15:0] s0, input int k);
    logic [15:0] s = (s0 == 16'h0) ? 16'hACE1 : s0;
    for (int i = 0; i < k; i++) s = stepLfsr(s);
    return s;
  endfunction

  function automatic logic [7:0] gcdMod(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] x = a;
    logic [7:0] y = b;
    logic [7:0] t;
    while (y != 8'd0) begin
      t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  // behavioural unit under test with injectable faults
  always @(posedge clk) begin
    if (!rstN) begin
      cutDone   <= 1'b0;
      cutResult <= 8'd0;
      mdlBusy   <= 1'b0;
    end else begin
      cutDone <= 1'b0;
      if (cutStart) begin
        if ({cutOpA, cutOpB} != expState) opErrs <= opErrs + 1;
        expState <= stepLfsr(expState);
        mdlBusy  <= 1'b1;
        mdlLat   <= $urandom_range(1, 9);
        mdlA     <= cutOpA;
        mdlB     <= cutOpB;
        mdlIdx   <= startCnt;
        startCnt <= startCnt + 1;
      end else if (mdlBusy) begin
        if (mdlLat <= 1) begin
          mdlBusy <= 1'b0;
          if (mdlIdx != hangIdx) begin
            cutDone   <= 1'b1;
            cutResult <= gcdMod(mdlA, mdlB) ^
                         (((mdlIdx == badIdx1) || (mdlIdx == badIdx2)) ? 8'h01 : 8'h00);
          end
        end else begin
          mdlLat <= mdlLat - 1;
        end
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic runTest(input logic [15:0] sd, input int n, input int b1,
                         input int b2, input int hg, input string tag);
    int waitCycles = 0;
    int nEff = (n == 0) ? 256 : n;
    int firstBad;
    logic [15:0] fs;
    @(negedge clk);
    startCnt  = 0;
    opErrs    = 0;
    expState  = (sd == 16'h0) ? 16'hACE1 : sd;
    badIdx1   = b1;
    badIdx2   = b2;
    hangIdx   = hg;
    seed      = sd;
    numVectors = n[15:0];
    testStart = 1'b1;
    @(negedge clk);
    testStart = 1'b0;
    check("R2", {tag, " done cleared at start"}, int'(testDone), 0);
    while (!testDone && waitCycles < 150000) begin
      @(negedge clk);
      waitCycles++;
    end
    check("R10", {tag, " run completes"}, int'(testDone), 1);
    check("R9", {tag, " vectors applied"}, int'(vectorsApplied), nEff);
    check("R9", {tag, " start strobes"}, startCnt, nEff);
    check("R3", {tag, " operand sequence errors"}, opErrs, 0);
    firstBad = -1;
    for (int i = 0; i < nEff; i++)
      if (firstBad < 0 && (i == b1 || i == b2 || i == hg)) firstBad = i;
    check("R6", {tag, " fail flag"}, int'(testFail), int'(firstBad >= 0));
    check("R10", {tag, " pass flag"}, int'(testPass), int'(firstBad < 0));
    check("R8", {tag, " watchdog flag"}, int'(wdogTrip), int'(hg >= 0 && hg < nEff));
    if (firstBad >= 0) begin
      fs = nthState(sd, firstBad);
      check("R7", {tag, " captured opA"}, int'(failOpA), int'(fs[15:8]));
      check("R7", {tag, " captured opB"}, int'(failOpB), int'(fs[7:0]));
      check("R5", {tag, " captured expected"}, int'(failExpected),
            int'(gcdMod(fs[15:8], fs[7:0])));
      if (firstBad == hg)
        check("R8", {tag, " captured actual after timeout"}, int'(failActual), 0);
      else
        check("R7", {tag, " captured actual"}, int'(failActual),
              int'(gcdMod(fs[15:8], fs[7:0]) ^ 8'h01));
    end
    repeat (3) @(negedge clk);
    check("R10", {tag, " done holds"}, int'(testDone), 1);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [15:0] rs;
    int rn, rb;
    void'($urandom(32'd4711));
    rstN = 1'b0; testStart = 1'b0; seed = 16'h0; numVectors = 16'd0;
    startCnt = 0; opErrs = 0; expState = 16'h0;
    badIdx1 = -1; badIdx2 = -1; hangIdx = -1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1", "testDone", int'(testDone), 0);
    check("R1", "testPass", int'(testPass), 0);
    check("R1", "testFail", int'(testFail), 0);
    check("R1", "wdogTrip", int'(wdogTrip), 0);
    check("R1", "cutStart", int'(cutStart), 0);
    check("R1", "vectorsApplied", int'(vectorsApplied), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R9 default count of 256, clean unit
    runTest(16'h5A3C, 0, -1, -1, -1, "default");
    // R2 zero seed replaced by default
    runTest(16'h0000, 12, -1, -1, -1, "zeroseed");
    // R5 corner operand pairs as vector 0
    runTest(16'h2A00, 1, -1, -1, -1, "b_zero");
    runTest(16'h0011, 1, -1, -1, -1, "a_zero");
    runTest(16'h3C3C, 1, -1, -1, -1, "equal");
    runTest(16'hFF01, 1, -1, -1, -1, "long_sub");
    // R6 R7 single and double mismatch
    runTest(16'h1234, 30, 5, -1, -1, "one_bad");
    runTest(16'hBEEF, 20, 3, 7, -1, "two_bad");
    // R8 hung unit at vector 2, then a later mismatch
    runTest(16'hC0DE, 10, 6, -1, 2, "hang");
    // R6 verdict cleared by a following clean run
    runTest(16'hC0DE, 10, -1, -1, -1, "rerun");
    // constrained random runs
    for (int k = 0; k < 6; k++) begin
      rs = 16'($urandom_range(1, 65535));
      rn = $urandom_range(1, 40);
      rb = (k % 2 == 0) ? $urandom_range(0, rn - 1) : -1;
      runTest(rs, rn, rb, -1, -1, "random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule